// File: doc/BRIEF.md
# Timer/Counter with Shared Watchdog Prescaler

This block holds an 8-bit timer/counter and a watchdog counter that share one 8-bit prescaler. A mode register decides which of the two owns the prescaler. It also sets the division code, whether the timer counts internal instruction cycles or transitions on an external pin, and which pin edge counts. A single 3-bit code sets the ratio for both users, but the ratio is twice as large when the timer owns the prescaler.

Software reaches the counter and the mode register through a simple write/read port. When the timer rolls over it sets an overflow flag. The flag raises an interrupt request only when the timer enable and the global enable are both set. The watchdog counts ticks from an outside slow oscillator and emits a one-cycle timeout pulse when it wraps. A clear strobe, used for both the clear command and the sleep command, restarts the watchdog.

Top module: `timer_wdt_prescale`

## Requirements
- R1: After reset the mode register reads 0xFF (prescaler owned by the watchdog, code 7, external source, falling edge). The counter reads 0x00, and the overflow flag and the timeout output are 0.
- R2: A write with regSel=1 loads the mode register at the next clock edge. Its fields are: bits 2:0 division code, bit 3 prescaler owner (1 = watchdog), bit 4 edge select (1 = falling), bit 5 source select (1 = external pin), bits 7:6 spare storage. regRdData shows the mode register when regSel=1 and the counter when regSel=0.
- R3: A write with regSel=0 loads the counter, and the counter does not increment on the clock edge after the write.
- R4: With the internal source selected and the prescaler owned by the watchdog, the counter increments once per clock cycle.
- R5: With the prescaler owned by the timer, the counter increments once every 2^(code+1) source events. A counter write also zeroes the prescaler, so after a write the first increment comes exactly 2^(code+1) events later.
- R6: With the external source selected, the pin passes through a two-flop synchroniser and one edge detector. The selected edge is counted, the other edge is ignored, and the count is visible after the third clock edge that follows the pin change.
- R7: An increment from 0xFF to 0x00 sets the overflow flag. The flag stays set until flagClr is pulsed, and a new overflow wins over a clear in the same cycle.
- R8: irqReq is high exactly when the overflow flag, timerIntEn and globalIntEn are all high.
- R9: The watchdog advances on every wdtTick when the timer owns the prescaler. When the watchdog owns the prescaler, it advances once every 2^code ticks. On the 2^WDT_W-th advance it wraps to zero and drives wdtTimeout high for one cycle.
- R10: wdtClear zeroes the watchdog count. It also zeroes the prescaler when the watchdog owns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the counter, 1 selects the mode register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| extPin | input | 1 | External count input (asynchronous) |
| wdtTick | input | 1 | Watchdog tick, one cycle per slow-oscillator period |
| wdtClear | input | 1 | Watchdog clear (clear or sleep command) |
| flagClr | input | 1 | Clears the overflow flag |
| timerIntEn | input | 1 | Timer interrupt enable |
| globalIntEn | input | 1 | Global interrupt enable |
| ovfFlag | output | 1 | Timer overflow flag |
| irqReq | output | 1 | Timer interrupt request |
| wdtTimeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The assertions assume that wdtTick and wdtClear are already synchronous single-cycle strobes. They also assume that a write strobe, not a pin event, is the only way the counter jumps by more than one. The bench drives every strobe and the pin only at falling clock edges, and keeps wdtClear and wdtTick apart. It holds each pin level for at least four cycles so that the synchroniser sees every transition. Before each overflow scenario it clears the flag, so that any earlier free-running count does not hide the flag being set.

// File: rtl/tmrwd_pkg.sv
package tmrwd_pkg;
  localparam int DATA_W = 8;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic [1:0]        spare;
    logic              extSrc;
    logic              fallEdge;
    logic              psToWdt;
    logic [CODE_W-1:0] divCode;
  } modeReg_t;

  typedef struct packed {
    logic       srcEvent;
    logic       wdtEvent;
    logic       psToWdt;
    logic [3:0] ratioBits;
    logic       tmrWrite;
    logic       tmrInhibit;
    logic       psClear;
    logic       wdtClear;
  } ctlStrobe_t;
endpackage

// File: rtl/tmrwd_ctrl.sv
module tmrwd_ctrl
  import tmrwd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              extPin,
  input  logic              wdtTick,
  input  logic              wdtClear,
  output modeReg_t          modeQ,
  output ctlStrobe_t        ctl
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevPin;
  logic                   inhibitQ;
  logic                   pinNow;
  logic                   riseEv;
  logic                   fallEv;
  logic                   extEvent;
  logic                   tmrWrite;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) syncQ[0] <= 1'b0;
          else        syncQ[0] <= extPin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) syncQ[gi] <= 1'b0;
          else        syncQ[gi] <= syncQ[gi-1];
      end
    end
  endgenerate

  assign pinNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevPin  <= 1'b0;
      inhibitQ <= 1'b0;
      modeQ    <= modeReg_t'('1);
    end else begin
      prevPin  <= pinNow;
      inhibitQ <= tmrWrite;
      if (regWrEn && regSel) modeQ <= modeReg_t'(regWrData);
    end
  end

  assign tmrWrite = regWrEn && !regSel;
  assign riseEv   = pinNow && !prevPin;
  assign fallEv   = !pinNow && prevPin;
  assign extEvent = modeQ.fallEdge ? fallEv : riseEv;

  always_comb begin
    ctl            = '0;
    ctl.srcEvent   = modeQ.extSrc ? extEvent : 1'b1;
    ctl.wdtEvent   = wdtTick;
    ctl.psToWdt    = modeQ.psToWdt;
    ctl.ratioBits  = {1'b0, modeQ.divCode} + {3'b000, !modeQ.psToWdt};
    ctl.tmrWrite   = tmrWrite;
    ctl.tmrInhibit = inhibitQ;
    ctl.psClear    = (tmrWrite && !modeQ.psToWdt) || (wdtClear && modeQ.psToWdt);
    ctl.wdtClear   = wdtClear;
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regSel) |=> (modeQ == modeReg_t'($past(regWrData)))); // R2
endmodule

// File: rtl/tmrwd_dp.sv
module tmrwd_dp
  import tmrwd_pkg::*;
#(
  parameter int PS_W  = 8,
  parameter int WDT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic              flagClr,
  output logic [DATA_W-1:0] tmrCount,
  output logic              ovfFlag,
  output logic              wdtTimeout
);
  logic [PS_W-1:0]  psCount;
  logic [PS_W:0]    maskWide;
  logic [PS_W-1:0]  psMask;
  logic             psEvent;
  logic             psTick;
  logic             tmrInc;
  logic             tmrWrap;
  logic             wdtStep;
  logic [WDT_W-1:0] wdtCount;

  assign maskWide = ({{PS_W{1'b0}}, 1'b1} << ctl.ratioBits) - 1'b1;
  assign psMask   = maskWide[PS_W-1:0];
  assign psEvent  = ctl.psToWdt ? ctl.wdtEvent : ctl.srcEvent;
  assign psTick   = psEvent && ((psCount & psMask) == psMask);
  assign tmrInc   = (ctl.psToWdt ? ctl.srcEvent : psTick) && !ctl.tmrInhibit;
  assign tmrWrap  = tmrInc && !ctl.tmrWrite && (tmrCount == '1);
  assign wdtStep  = ctl.psToWdt ? psTick : ctl.wdtEvent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           psCount <= '0;
    else if (ctl.psClear) psCount <= '0;
    else if (psEvent)     psCount <= psCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmrCount <= '0;
      ovfFlag  <= 1'b0;
    end else begin
      if (ctl.tmrWrite)  tmrCount <= wrData;
      else if (tmrInc)   tmrCount <= tmrCount + 1'b1;
      if (tmrWrap)       ovfFlag <= 1'b1;
      else if (flagClr)  ovfFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdtCount   <= '0;
      wdtTimeout <= 1'b0;
    end else if (ctl.wdtClear) begin
      wdtCount   <= '0;
      wdtTimeout <= 1'b0;
    end else begin
      wdtTimeout <= wdtStep && (wdtCount == '1);
      if (wdtStep) wdtCount <= wdtCount + 1'b1;
    end
  end

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.tmrInhibit && !ctl.tmrWrite) |=> (tmrCount == $past(tmrCount))); // R3
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctl.tmrWrite) && ($past(tmrCount) == '1) && (tmrCount == '0)) |-> ovfFlag); // R7
  AST_PS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.psClear |=> (psCount == '0)); // R5
  AST_WDT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wdtClear |=> (wdtCount == '0 && !wdtTimeout)); // R10
  AST_TIMEOUT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wdtTimeout |-> (wdtCount == '0)); // R9
  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdtTimeout |=> !wdtTimeout); // R9
endmodule

// File: rtl/timer_wdt_prescale.sv
module timer_wdt_prescale
  import tmrwd_pkg::*;
#(
  parameter int PS_W        = 8,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              extPin,
  input  logic              wdtTick,
  input  logic              wdtClear,
  input  logic              flagClr,
  input  logic              timerIntEn,
  input  logic              globalIntEn,
  output logic              ovfFlag,
  output logic              irqReq,
  output logic              wdtTimeout
);
  modeReg_t          modeQ;
  ctlStrobe_t        ctl;
  logic [DATA_W-1:0] tmrCount;

  tmrwd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .extPin(extPin), .wdtTick(wdtTick),
    .wdtClear(wdtClear), .modeQ(modeQ), .ctl(ctl)
  );

  tmrwd_dp #(.PS_W(PS_W), .WDT_W(WDT_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wrData(regWrData),
    .flagClr(flagClr), .tmrCount(tmrCount), .ovfFlag(ovfFlag),
    .wdtTimeout(wdtTimeout)
  );

  assign regRdData = regSel ? DATA_W'(modeQ) : tmrCount;
  assign irqReq    = ovfFlag && timerIntEn && globalIntEn;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> (ovfFlag && globalIntEn)); // R8
endmodule

// File: tb/test_timer_wdt_prescale.sv
module test_timer_wdt_prescale;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrEn = 1'b0, regSel = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic extPin = 1'b0, wdtTick = 1'b0, wdtClear = 1'b0, flagClr = 1'b0;
  logic timerIntEn = 1'b0, globalIntEn = 1'b0;
  logic ovfFlag, irqReq, wdtTimeout;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  timer_wdt_prescale i_timer_wdt_prescale (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .extPin(extPin),
    .wdtTick(wdtTick), .wdtClear(wdtClear), .flagClr(flagClr),
    .timerIntEn(timerIntEn), .globalIntEn(globalIntEn), .ovfFlag(ovfFlag),
    .irqReq(irqReq), .wdtTimeout(wdtTimeout)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic sel, output logic [7:0] v);
    regSel = sel;
    #1 v = regRdData;
  endtask

  task automatic pulseClear();
    @(negedge clk); wdtClear = 1'b1;
    @(negedge clk); wdtClear = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] v;
    @(negedge clk);
    rdReg(1'b1, v); check("R1 mode", v, 8'hFF);
    rdReg(1'b0, v); check("R1 counter", v, 8'h00);
    check("R1 flag", ovfFlag, 0);
    check("R1 timeout", wdtTimeout, 0);
  endtask

  task automatic testModeReadback();
    logic [7:0] v;
    wrReg(1'b1, 8'h5A);
    rdReg(1'b1, v); check("R2 mode readback", v, 8'h5A);
  endtask

  task automatic testInternalCount();
    logic [7:0] v;
    wrReg(1'b1, 8'h08);
    wrReg(1'b0, 8'h10);
    rdReg(1'b0, v); check("R2 counter load", v, 8'h10);
    @(negedge clk);
    rdReg(1'b0, v); check("R3 inhibit after write", v, 8'h10);
    repeat (5) @(negedge clk);
    rdReg(1'b0, v); check("R4 one per cycle", v, 8'h15);
  endtask

  task automatic testPrescaledTimer();
    logic [7:0] v;
    wrReg(1'b1, 8'h01);
    wrReg(1'b0, 8'h00);
    repeat (7) @(negedge clk);
    rdReg(1'b0, v); check("R5 ratio4 before", v, 8'h01);
    @(negedge clk);
    rdReg(1'b0, v); check("R5 ratio4 second", v, 8'h02);
    wrReg(1'b1, 8'h07);
    wrReg(1'b0, 8'h00);
    repeat (255) @(negedge clk);
    rdReg(1'b0, v); check("R5 ratio256 before", v, 8'h00);
    @(negedge clk);
    rdReg(1'b0, v); check("R5 ratio256 tick", v, 8'h01);
  endtask

  task automatic testOverflow();
    logic [7:0] v;
    wrReg(1'b1, 8'h08);
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    wrReg(1'b0, 8'hFE);
    @(negedge clk);
    @(negedge clk);
    rdReg(1'b0, v); check("R7 at FF", v, 8'hFF);
    check("R7 flag not yet", ovfFlag, 0);
    @(negedge clk);
    rdReg(1'b0, v); check("R7 wrapped", v, 8'h00);
    check("R7 flag set", ovfFlag, 1);
    timerIntEn = 1'b1; globalIntEn = 1'b0;
    #1 check("R8 global off", irqReq, 0);
    globalIntEn = 1'b1;
    #1 check("R8 both on", irqReq, 1);
    timerIntEn = 1'b0;
    #1 check("R8 timer off", irqReq, 0);
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    check("R7 flag cleared", ovfFlag, 0);
    globalIntEn = 1'b0;
  endtask

  task automatic testExternal();
    logic [7:0] v;
    wrReg(1'b1, 8'h28);
    wrReg(1'b0, 8'h00);
    repeat (2) @(negedge clk);
    extPin = 1'b1;
    repeat (2) @(negedge clk);
    rdReg(1'b0, v); check("R6 sync latency", v, 8'h00);
    @(negedge clk);
    rdReg(1'b0, v); check("R6 rising counted", v, 8'h01);
    @(negedge clk); extPin = 1'b0;
    repeat (4) @(negedge clk);
    rdReg(1'b0, v); check("R6 falling ignored", v, 8'h01);
    for (int i = 0; i < 2; i++) begin
      extPin = 1'b1; repeat (4) @(negedge clk);
      extPin = 1'b0; repeat (4) @(negedge clk);
    end
    rdReg(1'b0, v); check("R6 rising pulses", v, 8'h03);
    wrReg(1'b1, 8'h38);
    wrReg(1'b0, 8'h00);
    extPin = 1'b1; repeat (4) @(negedge clk);
    rdReg(1'b0, v); check("R6 rising ignored", v, 8'h00);
    extPin = 1'b0; repeat (3) @(negedge clk);
    rdReg(1'b0, v); check("R6 falling counted", v, 8'h01);
  endtask

  task automatic runTicks(input int n);
    @(negedge clk); wdtTick = 1'b1;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic testWatchdog();
    wrReg(1'b1, 8'h08);
    pulseClear();
    runTicks(255);
    @(negedge clk);
    check("R9 no timeout at 255", wdtTimeout, 0);
    @(negedge clk);
    check("R9 timeout at 256", wdtTimeout, 1);
    wdtTick = 1'b0;
    @(negedge clk);
    check("R9 single pulse", wdtTimeout, 0);

    wrReg(1'b1, 8'h0A);
    pulseClear();
    runTicks(1023);
    @(negedge clk);
    check("R9 ratio4 no timeout", wdtTimeout, 0);
    @(negedge clk);
    check("R9 ratio4 timeout", wdtTimeout, 1);
    wdtTick = 1'b0;

    wrReg(1'b1, 8'h08);
    pulseClear();
    runTicks(200);
    @(negedge clk); wdtTick = 1'b0;
    pulseClear();
    runTicks(255);
    @(negedge clk);
    check("R10 clear restarts", wdtTimeout, 0);
    @(negedge clk);
    check("R10 full count after clear", wdtTimeout, 1);
    wdtTick = 1'b0;

    wrReg(1'b1, 8'h01);
    pulseClear();
    runTicks(255);
    @(negedge clk);
    check("R9 raw ticks no timeout", wdtTimeout, 0);
    @(negedge clk);
    check("R9 raw ticks timeout", wdtTimeout, 1);
    wdtTick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testModeReadback();
    testInternalCount();
    testPrescaledTimer();
    testOverflow();
    testExternal();
    testWatchdog();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule